// File: doc/BRIEF.md
# Shared-Memory Panel Refresh Engine

This block keeps an RGB TFT panel refreshed straight from a frame image held in an SRAM that it shares with a CPU. No separate display controller is involved. The engine produces the pixel clock, the line and frame sync pulses and the data-enable strobe. It reads the frame image from memory in order, one active row after another, and places one pixel on the colour bus in each pixel clock period. At the last pixel of every line it raises a short event, which software can use to pace its work.

All timing is programmable. Each axis has its own sync width, back porch, active size and front porch. The start address of the image and the active level of each timing pin can also be set. These settings are latched only when a new frame begins, so software may rewrite them at any moment without tearing the picture. The CPU writes new pixels through the same memory port and always wins that port. A small line FIFO between memory reads and the panel covers these pauses. If the FIFO runs dry while the panel expects valid pixels, a sticky underrun flag is set.

One pixel lasts two system clocks. That leaves the fetch side one spare memory slot per pixel to refill the FIFO after a CPU burst.

Top module: `lcd_scan_engine`

## Requirements
- R1: Each line lasts cfgHSync+cfgHBack+cfgHActive+cfgHFront pixel periods, in that order (sync, back porch, active, front porch). lcdHsync is at its active level for exactly the first cfgHSync pixels of the line.
- R2: Each frame lasts cfgVSync+cfgVBack+cfgVActive+cfgVFront lines, in that order. lcdVsync is at its active level for every pixel of the first cfgVSync lines. Frames repeat without a gap.
- R3: lcdDen is at its active level only for pixels that lie in both the horizontal and the vertical active window. It is inactive during every sync and porch pixel.
- R4: The active pixel at column x of active row y shows the memory word at cfgBase + y*cfgHActive + x. The address restarts at cfgBase on every frame. lcdData is zero for every pixel outside the active window.
- R5: One pixel lasts one lcdPclk period, which is two clk cycles. The pixel outputs change only on the clk edge at which lcdPclk falls, so they are stable while lcdPclk is high.
- R6: lineDone is a single-clk pulse. It is high during the low half of the last pixel period of every line, and only then.
- R7: While cpuWrEn is high, the memory port carries the CPU write in the same cycle: memEn=1, memWe=1, memAddr=cpuAddr, memWData=cpuData. No scan-out read is issued in that cycle.
- R8: cfgPolarity bit 0 applies to lcdHsync, bit 1 to lcdVsync and bit 2 to lcdDen. A bit value of 1 makes the pin active-low. A bit value of 0 makes it active-high.
- R9: All cfg inputs are sampled at the start of a frame, at the first pixel of the vertical sync interval. A change made mid-frame takes effect from the next frame.
- R10: If an active pixel is due while the line FIFO is empty, that pixel is shown as zero and underrun goes to 1. underrun stays at 1 until reset.
- R11: During and directly after reset, lcdHsync, lcdVsync, lcdDen, lcdPclk, lcdData, lineDone and underrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one pixel every two cycles |
| rstN | input | 1 | Active-low synchronous reset |
| cfgHSync | input | CNT_W | Horizontal sync width in pixels |
| cfgHBack | input | CNT_W | Horizontal back porch in pixels |
| cfgHActive | input | CNT_W | Active pixels per line |
| cfgHFront | input | CNT_W | Horizontal front porch in pixels |
| cfgVSync | input | CNT_W | Vertical sync width in lines |
| cfgVBack | input | CNT_W | Vertical back porch in lines |
| cfgVActive | input | CNT_W | Active lines per frame |
| cfgVFront | input | CNT_W | Vertical front porch in lines |
| cfgBase | input | ADDR_W | Memory address of the first active pixel |
| cfgPolarity | input | 3 | Active-low selects for hsync, vsync and den |
| cpuWrEn | input | 1 | CPU write strobe; takes priority on the memory port |
| cpuAddr | input | ADDR_W | CPU write address |
| cpuData | input | DATA_W | CPU write data |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write select (1 = write) |
| memAddr | output | ADDR_W | Memory address |
| memWData | output | DATA_W | Memory write data |
| memRData | input | DATA_W | Memory read data, valid one cycle after a read |
| lcdData | output | DATA_W | Colour data bus to the panel |
| lcdHsync | output | 1 | Line sync |
| lcdVsync | output | 1 | Frame sync |
| lcdDen | output | 1 | Data enable |
| lcdPclk | output | 1 | Pixel clock |
| lineDone | output | 1 | End-of-line event pulse |
| underrun | output | 1 | Sticky FIFO-underrun flag |

## Verification
A corrupted line or frame counter shows up on lcdHsync, lcdVsync, lcdDen or lineDone at the very next pixel whose expected level differs. Every pixel of several frames is compared, so such an error surfaces within one line. A wrong fetch address, a stale FIFO entry or a wrong flush at a frame boundary shows up as a wrong word at the first active pixel that follows. The base and the geometry are changed between frames so that a missed frame-start sample is caught on the first line of the new frame. The CPU-priority path is observed on the memory port in the same cycle as the write, and a forced starvation shows whether the underrun flag rises and then holds.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // Strobes passed from timing control to the fetch datapath.
  typedef struct packed {
    logic frameStart;  // shadow load, fetch restart, FIFO flush
    logic pixStep;     // a pixel is emitted on this edge
    logic popReq;      // the emitted pixel lies in the active window
  } scanStrobe_t;
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgHSync,
  input  logic [CNT_W-1:0]  cfgHBack,
  input  logic [CNT_W-1:0]  cfgHActive,
  input  logic [CNT_W-1:0]  cfgHFront,
  input  logic [CNT_W-1:0]  cfgVSync,
  input  logic [CNT_W-1:0]  cfgVBack,
  input  logic [CNT_W-1:0]  cfgVActive,
  input  logic [CNT_W-1:0]  cfgVFront,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [2:0]        cfgPolarity,
  output scanStrobe_t       strobe,
  output logic [CNT_W-1:0]  shHActive,
  output logic [CNT_W-1:0]  shVActive,
  output logic [ADDR_W-1:0] shBase,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              denOut,
  output logic              pclkOut,
  output logic              lineDone
);
  localparam int TOT_W = CNT_W + 2;

  logic [CNT_W-1:0] shHS, shHB, shHF, shVS, shVB, shVF;
  logic [2:0]       shPol;
  logic [TOT_W-1:0] hCnt, vCnt;
  logic [TOT_W-1:0] hTot, vTot, hActLo, hActHi, vActLo, vActHi;
  logic             phase, started;
  logic             lastCol, lastRow, inActive, frameStart, pixStep;

  assign hActLo = TOT_W'(shHS) + TOT_W'(shHB);
  assign hActHi = hActLo + TOT_W'(shHActive);
  assign hTot   = hActHi + TOT_W'(shHF);
  assign vActLo = TOT_W'(shVS) + TOT_W'(shVB);
  assign vActHi = vActLo + TOT_W'(shVActive);
  assign vTot   = vActHi + TOT_W'(shVF);

  assign lastCol    = (hCnt == hTot - 1'b1);
  assign lastRow    = (vCnt == vTot - 1'b1);
  assign inActive   = (hCnt >= hActLo) && (hCnt < hActHi) &&
                      (vCnt >= vActLo) && (vCnt < vActHi);
  assign pixStep    = phase;
  assign frameStart = !started || (pixStep && lastCol && lastRow);

  assign strobe.frameStart = frameStart;
  assign strobe.pixStep    = pixStep;
  assign strobe.popReq     = pixStep && inActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 1'b0; started <= 1'b0; pclkOut <= 1'b0; lineDone <= 1'b0;
      hCnt <= '0; vCnt <= '0;
      hsyncOut <= 1'b0; vsyncOut <= 1'b0; denOut <= 1'b0;
      shHS <= '0; shHB <= '0; shHActive <= '0; shHF <= '0;
      shVS <= '0; shVB <= '0; shVActive <= '0; shVF <= '0;
      shBase <= '0; shPol <= '0;
    end else begin
      phase    <= ~phase;
      pclkOut  <= started & ~phase;
      lineDone <= pixStep & lastCol;
      if (frameStart) begin
        started <= 1'b1;
        shHS <= cfgHSync; shHB <= cfgHBack; shHActive <= cfgHActive; shHF <= cfgHFront;
        shVS <= cfgVSync; shVB <= cfgVBack; shVActive <= cfgVActive; shVF <= cfgVFront;
        shBase <= cfgBase; shPol <= cfgPolarity;
      end
      if (pixStep) begin
        hsyncOut <= (hCnt < TOT_W'(shHS)) ^ shPol[0];
        vsyncOut <= (vCnt < TOT_W'(shVS)) ^ shPol[1];
        denOut   <= inActive ^ shPol[2];
        if (lastCol) begin
          hCnt <= '0;
          vCnt <= lastRow ? '0 : vCnt + 1'b1;
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
    end
  end

  // R6
  line_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);
  // R5
  pix_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(denOut) |-> !pclkOut);
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(shHActive) && $stable(shBase) && $stable(shPol)));
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch
  import lcd_scan_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 10,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strobe,
  input  logic [CNT_W-1:0]  shHActive,
  input  logic [CNT_W-1:0]  shVActive,
  input  logic [ADDR_W-1:0] shBase,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] lcdData,
  output logic              underrun
);
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int FILL_W = PTR_W + 2;

  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0]  fetchCol, fetchRow;
  logic [ADDR_W-1:0] fetchOff;
  logic              rdPending, fetchDone, room, fetchIssue, push, pop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fetchDone  = (fetchRow >= shVActive);
  assign room       = (fill + FILL_W'(rdPending)) < FILL_W'(FIFO_DEPTH);
  assign fetchIssue = !cpuWrEn && !strobe.frameStart && !fetchDone && room;
  assign push       = rdPending;
  assign pop        = strobe.popReq && (fill != '0);

  assign memEn    = cpuWrEn | fetchIssue;
  assign memWe    = cpuWrEn;
  assign memAddr  = cpuWrEn ? cpuAddr : shBase + fetchOff;
  assign memWData = cpuData;

  always_ff @(posedge clk) begin
    if (push && !strobe.frameStart) fifoMem[wrPtr] <= memRData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fill <= '0; rdPending <= 1'b0;
      fetchCol <= '0; fetchRow <= '0; fetchOff <= '0;
      lcdData <= '0; underrun <= 1'b0;
    end else begin
      if (strobe.pixStep) lcdData <= pop ? fifoMem[rdPtr] : '0;
      if (strobe.popReq && fill == '0) underrun <= 1'b1;
      if (strobe.frameStart) begin
        wrPtr <= '0; rdPtr <= '0; fill <= '0; rdPending <= 1'b0;
        fetchCol <= '0; fetchRow <= '0; fetchOff <= '0;
      end else begin
        rdPending <= fetchIssue;
        if (push) wrPtr <= nextPtr(wrPtr);
        if (pop)  rdPtr <= nextPtr(rdPtr);
        fill <= fill + FILL_W'(push) - FILL_W'(pop);
        if (fetchIssue) begin
          fetchOff <= fetchOff + 1'b1;
          if (fetchCol == shHActive - 1'b1) begin
            fetchCol <= '0;
            fetchRow <= fetchRow + 1'b1;
          end else begin
            fetchCol <= fetchCol + 1'b1;
          end
        end
      end
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (fill < FILL_W'(FIFO_DEPTH)));
  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);
  // R7
  cpu_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> !rdPending);
endmodule

// File: rtl/lcd_scan_engine.sv
module lcd_scan_engine
  import lcd_scan_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 10,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgHSync,
  input  logic [CNT_W-1:0]  cfgHBack,
  input  logic [CNT_W-1:0]  cfgHActive,
  input  logic [CNT_W-1:0]  cfgHFront,
  input  logic [CNT_W-1:0]  cfgVSync,
  input  logic [CNT_W-1:0]  cfgVBack,
  input  logic [CNT_W-1:0]  cfgVActive,
  input  logic [CNT_W-1:0]  cfgVFront,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [2:0]        cfgPolarity,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] lcdData,
  output logic              lcdHsync,
  output logic              lcdVsync,
  output logic              lcdDen,
  output logic              lcdPclk,
  output logic              lineDone,
  output logic              underrun
);
  scanStrobe_t       strobe;
  logic [CNT_W-1:0]  shHActive, shVActive;
  logic [ADDR_W-1:0] shBase;

  lcd_scan_timing #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_timing (
    .clk(clk), .rstN(rstN),
    .cfgHSync(cfgHSync), .cfgHBack(cfgHBack), .cfgHActive(cfgHActive), .cfgHFront(cfgHFront),
    .cfgVSync(cfgVSync), .cfgVBack(cfgVBack), .cfgVActive(cfgVActive), .cfgVFront(cfgVFront),
    .cfgBase(cfgBase), .cfgPolarity(cfgPolarity),
    .strobe(strobe), .shHActive(shHActive), .shVActive(shVActive), .shBase(shBase),
    .hsyncOut(lcdHsync), .vsyncOut(lcdVsync), .denOut(lcdDen), .pclkOut(lcdPclk),
    .lineDone(lineDone)
  );

  lcd_scan_fetch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
                   .FIFO_DEPTH(FIFO_DEPTH)) u_fetch (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .shHActive(shHActive), .shVActive(shVActive), .shBase(shBase),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .lcdData(lcdData), .underrun(underrun)
  );
endmodule

// File: tb/lcd_scan_engine_tb.sv
module lcd_scan_engine_tb;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CW = 10;

  typedef struct {
    int hs, hb, ha, hf, vs, vb, va, vf, base;
    logic [2:0] pol;
  } cfg_t;

  typedef struct packed {
    logic hs; logic vs; logic de; logic ld; logic [DW-1:0] d;
  } pix_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgHSync, cfgHBack, cfgHActive, cfgHFront;
  logic [CW-1:0] cfgVSync, cfgVBack, cfgVActive, cfgVFront;
  logic [AW-1:0] cfgBase;
  logic [2:0]    cfgPolarity;
  logic          cpuWrEn = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuData = '0;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWData, memRData;
  logic [DW-1:0] lcdData;
  logic          lcdHsync, lcdVsync, lcdDen, lcdPclk, lineDone, underrun;

  logic [DW-1:0] mem [256];
  pix_t expQ[$];
  int   errors = 0;
  int   checks = 0;
  int   pixSeen = 0;
  logic ldLow = 1'b0;

  always #5 clk = ~clk;

  lcd_scan_engine #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .FIFO_DEPTH(16)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgHSync(cfgHSync), .cfgHBack(cfgHBack), .cfgHActive(cfgHActive), .cfgHFront(cfgHFront),
    .cfgVSync(cfgVSync), .cfgVBack(cfgVBack), .cfgVActive(cfgVActive), .cfgVFront(cfgVFront),
    .cfgBase(cfgBase), .cfgPolarity(cfgPolarity),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .lcdData(lcdData), .lcdHsync(lcdHsync), .lcdVsync(lcdVsync),
    .lcdDen(lcdDen), .lcdPclk(lcdPclk), .lineDone(lineDone), .underrun(underrun)
  );

  // Memory model: one-cycle read latency.
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWData;
      else       memRData <= mem[memAddr];
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic applyCfg(input cfg_t c);
    cfgHSync = CW'(c.hs); cfgHBack = CW'(c.hb); cfgHActive = CW'(c.ha); cfgHFront = CW'(c.hf);
    cfgVSync = CW'(c.vs); cfgVBack = CW'(c.vb); cfgVActive = CW'(c.va); cfgVFront = CW'(c.vf);
    cfgBase = AW'(c.base); cfgPolarity = c.pol;
  endtask

  // Driver: pushes the expected pixel stream of one frame (R1-R4, R6, R8).
  task automatic pushFrame(input cfg_t c);
    int hTot = c.hs + c.hb + c.ha + c.hf;
    int vTot = c.vs + c.vb + c.va + c.vf;
    for (int v = 0; v < vTot; v++) begin
      for (int h = 0; h < hTot; h++) begin
        pix_t p;
        logic act;
        act  = (h >= c.hs + c.hb) && (h < c.hs + c.hb + c.ha) &&
               (v >= c.vs + c.vb) && (v < c.vs + c.vb + c.va);
        p.hs = (h < c.hs) ^ c.pol[0];
        p.vs = (v < c.vs) ^ c.pol[1];
        p.de = act ^ c.pol[2];
        p.ld = (h == hTot - 1);
        p.d  = act ? mem[8'(c.base + (v - c.vs - c.vb) * c.ha + (h - c.hs - c.hb))] : '0;
        expQ.push_back(p);
      end
    end
  endtask

  // Monitor: lineDone sampled in the low half, pixel outputs in the high half (R5).
  always @(negedge clk) begin
    if (rstN) begin
      if (!lcdPclk) begin
        ldLow = lineDone;
      end else begin
        pixSeen++;
        check(lineDone == 1'b0, "R6 pulse outside low half", int'(lineDone), 0);
        if (expQ.size() > 0) begin
          pix_t e;
          e = expQ.pop_front();
          check(lcdHsync == e.hs, "R1/R8 hsync", int'(lcdHsync), int'(e.hs));
          check(lcdVsync == e.vs, "R2/R8 vsync", int'(lcdVsync), int'(e.vs));
          check(lcdDen == e.de, "R3/R8 den", int'(lcdDen), int'(e.de));
          check(lcdData == e.d, "R4 data", int'(lcdData), int'(e.d));
          check(ldLow == e.ld, "R6 lineDone", int'(ldLow), int'(e.ld));
        end
      end
    end
  end

  // CPU write burst; every cycle checks the memory port (R7).
  task automatic cpuBurst(input logic [AW-1:0] addr0, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpuWrEn = 1'b1;
      cpuAddr = addr0 + AW'(i % 8);
      cpuData = DW'(16'hA000 + i);
      #1;
      check(memEn && memWe && memAddr == cpuAddr && memWData == cpuData,
            "R7 cpu priority", int'({memEn, memWe, memAddr}), int'({2'b11, cpuAddr}));
    end
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    cfg_t cA, cB;
    cA = '{hs:2, hb:3, ha:8, hf:2, vs:1, vb:1, va:3, vf:1, base:'h10, pol:3'b000};
    cB = '{hs:3, hb:2, ha:6, hf:3, vs:2, vb:1, va:4, vf:2, base:'h40, pol:3'b101};
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 37 + 11);
    applyCfg(cA);
    repeat (4) @(negedge clk);
    // R11 reset state
    check({lcdHsync, lcdVsync, lcdDen, lcdPclk, lineDone, underrun} == 6'b0,
          "R11 reset controls", int'({lcdHsync, lcdVsync, lcdDen, lcdPclk, lineDone, underrun}), 0);
    check(lcdData == '0, "R11 reset data", int'(lcdData), 0);
    pushFrame(cA);
    pushFrame(cA);
    pushFrame(cB);  // R9: B written mid-frame 2, visible from frame 3
    pushFrame(cB);
    rstN = 1'b1;
    @(negedge clk);
    check({lcdHsync, lcdVsync, lcdDen, lcdPclk, underrun} == 5'b0,
          "R11 after release", int'({lcdHsync, lcdVsync, lcdDen, lcdPclk, underrun}), 0);
    wait (pixSeen >= 130);
    @(negedge clk);
    applyCfg(cB);  // R9 mid-frame change
    wait (pixSeen >= 330);
    cpuBurst(8'hC0, 4);  // R7 short burst, covered by the FIFO
    wait (expQ.size() == 0);
    @(negedge clk);
    check(underrun == 1'b0, "R10 no underrun yet", int'(underrun), 0);
    // R10: starve the FIFO through the active area of frame 5 (den active-low)
    while (lcdDen !== 1'b0) @(negedge clk);
    cpuBurst(8'hF0, 200);
    check(underrun == 1'b1, "R10 underrun set", int'(underrun), 1);
    repeat (400) @(negedge clk);
    check(underrun == 1'b1, "R10 underrun sticky", int'(underrun), 1);
    finishRun();
  end
endmodule